// File: doc/BRIEF.md
# Shared IRQ1 Source Aggregator with Fixed Vector

This block combines three interrupt sources onto one interrupt request line: the receive event of serial input port 1, the receive event of serial input port 2, and the real-time clock alarm. Each source is caught on its rising edge and held as pending until the consumer clears it. The consumer is, for example, the logic that reads a data buffer or acknowledges the alarm. The request line stays high while any enabled source is still pending, so two events that overlap are both kept.

Software finds out which source fired by reading a status register. It can mask the alarm source through a mask register. On an interrupt acknowledge, the block always returns the fixed vector 71h, whatever base vector the controller initialisation has programmed. The programmed base is kept and can be read back, so that dispatch software can forward keyboard events to the usual base+1 vector. A small acknowledge state machine (IDLE, DELIVER, HOLD) produces a one-cycle vector strobe for each acknowledge.

Top module: `irq_share_unit`

## Requirements
- R1: After reset the following hold: no source is pending, `irq_o` is 0, the alarm mask reads 1 (masked), the base readback is 08h, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: A source becomes pending on the clock edge at which its input is first seen high after being low. A source input that stays high does not set pending again after it has been cleared.
- R3: A pending source stays pending until its clear input is pulsed. If a new rising edge and a clear arrive in the same cycle, the source stays pending.
- R4: `irq_o` is 1 exactly when port 1 is pending, or port 2 is pending, or the alarm is pending and not masked.
- R5: Register select 0 (status) reads bit 2 = port 1 pending, bit 3 = port 2 pending and bit 4 = alarm pending. All other bits read 0.
- R6: Register select 1 (mask) holds bit 0 only, and other bits read 0. Bit 0 = 1 removes the alarm from `irq_o`, while status bit 4 still shows the alarm as pending.
- R7: A write to register select 2 (initialisation word) stores data bits 7:3 as the base. A read of select 2 returns the base in bits 7:3 and 0 in bits 2:0. Select 3 reads 0 and a write to it changes nothing.
- R8: A rising `inta_i` while the FSM is in IDLE moves it to DELIVER on the next edge. DELIVER drives `vec_valid_o` = 1 and `vec_o` = 71h for exactly one cycle, whatever the programmed base. When not in DELIVER, `vec_o` is 0.
- R9: If `inta_i` is still high after DELIVER, the FSM waits in HOLD and delivers no further vector until `inta_i` has gone low and the FSM has returned to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_kbd_i | input | 1 | Port 1 receive event |
| src_aux_i | input | 1 | Port 2 receive event |
| src_alarm_i | input | 1 | Clock alarm event |
| clr_kbd_i | input | 1 | Clear port 1 pending |
| clr_aux_i | input | 1 | Clear port 2 pending |
| clr_alarm_i | input | 1 | Clear alarm pending |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 base, 3 unused |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Shared IRQ1 request |
| inta_i | input | 1 | Interrupt acknowledge |
| vec_valid_o | output | 1 | Vector strobe |
| vec_o | output | 8 | Delivered vector (71h when valid) |

## Verification
The bench builds the block with its default parameters: 8-bit registers, vector 71h and reset base 08h. These are small enough to sweep every one of the eight source combinations under both alarm mask settings, and to write all 256 initialisation words. After each base write the bench runs a full acknowledge cycle, which shows that the delivered vector never follows the programmed base. Directed cases cover a clear and an edge arriving together, a source held high across a clear, and writes to the unused select.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELIVER = 2'd1,
        ST_HOLD    = 2'd2
    } ack_state_t;

    localparam int SRC_N     = 3;
    localparam int SRC_KBD   = 0;
    localparam int SRC_AUX   = 1;
    localparam int SRC_ALARM = 2;

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_MASK   = 2'd1;
    localparam logic [1:0] SEL_BASE   = 2'd2;

    localparam int STAT_LSB  = 2;
    localparam int BASE_LSB  = 3;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic rise;

    assign rise = src_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= src_i;
            pend_o <= rise | (pend_o & ~clr_i);
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_share_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  BASE_RESET = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic [SRC_N-1:0]  pend_i,
    output logic              alarm_mask_o,
    output logic [DATA_W-1:0] reg_rdata_o
);
    localparam int BASE_W = DATA_W - BASE_LSB;

    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_mask_o <= 1'b1;
            base_q       <= BASE_RESET[DATA_W-1:BASE_LSB];
        end else if (reg_wr_i) begin
            if (reg_sel_i == SEL_MASK) alarm_mask_o <= reg_wdata_i[0];
            if (reg_sel_i == SEL_BASE) base_q <= reg_wdata_i[DATA_W-1:BASE_LSB];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_sel_i)
            SEL_STATUS: reg_rdata_o[STAT_LSB +: SRC_N] = pend_i;
            SEL_MASK:   reg_rdata_o[0] = alarm_mask_o;
            SEL_BASE:   reg_rdata_o[DATA_W-1:BASE_LSB] = base_q;
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_share_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] FIXED_VEC = 8'h71
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inta_i,
    output logic              vec_valid_o,
    output logic [DATA_W-1:0] vec_o
);
    ack_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (inta_i) state_d = ST_DELIVER;
            ST_DELIVER: state_d = inta_i ? ST_HOLD : ST_IDLE;
            ST_HOLD:    if (!inta_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        vec_valid_o = (state_q == ST_DELIVER);
        vec_o       = vec_valid_o ? FIXED_VEC : '0;
    end
endmodule

// File: rtl/irq_share_unit.sv
module irq_share_unit
    import irq_share_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  FIXED_VEC  = 8'h71,
    parameter logic [7:0]  BASE_RESET = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_kbd_i,
    input  logic              src_aux_i,
    input  logic              src_alarm_i,
    input  logic              clr_kbd_i,
    input  logic              clr_aux_i,
    input  logic              clr_alarm_i,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    input  logic              inta_i,
    output logic              vec_valid_o,
    output logic [DATA_W-1:0] vec_o
);
    logic [SRC_N-1:0] src_v, clr_v, pend_v, enable_v;
    logic             alarm_mask;

    assign src_v = {src_alarm_i, src_aux_i, src_kbd_i};
    assign clr_v = {clr_alarm_i, clr_aux_i, clr_kbd_i};

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        irq_edge_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_v[i]),
            .clr_i  (clr_v[i]),
            .pend_o (pend_v[i])
        );
        if (i == SRC_ALARM) begin : g_masked
            assign enable_v[i] = ~alarm_mask;
        end else begin : g_open
            assign enable_v[i] = 1'b1;
        end
    end

    assign irq_o = |(pend_v & enable_v);

    irq_cfg_regs #(.DATA_W(DATA_W), .BASE_RESET(BASE_RESET)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel_i    (reg_sel_i),
        .reg_wr_i     (reg_wr_i),
        .reg_wdata_i  (reg_wdata_i),
        .pend_i       (pend_v),
        .alarm_mask_o (alarm_mask),
        .reg_rdata_o  (reg_rdata_o)
    );

    irq_ack_fsm #(.DATA_W(DATA_W), .FIXED_VEC(FIXED_VEC[DATA_W-1:0])) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .inta_i      (inta_i),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o)
    );
endmodule

// File: rtl/irq_share_checker.sv
module irq_share_checker #(
    parameter int         DATA_W    = 8,
    parameter logic [7:0] FIXED_VEC = 8'h71
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_kbd_i,
    input logic              clr_aux_i,
    input logic              clr_alarm_i,
    input logic              reg_wr_i,
    input logic              irq_o,
    input logic              inta_i,
    input logic              vec_valid_o,
    input logic [DATA_W-1:0] vec_o
);
    AST_VEC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> vec_o == FIXED_VEC[DATA_W-1:0]); // R8
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> vec_o == '0); // R8
    AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o); // R9
    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid_o) |-> $past(inta_i)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_kbd_i && !clr_aux_i && !clr_alarm_i && !reg_wr_i) |=> irq_o); // R3
endmodule

bind irq_share_unit irq_share_checker #(.DATA_W(DATA_W), .FIXED_VEC(FIXED_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_kbd_i   (clr_kbd_i),
    .clr_aux_i   (clr_aux_i),
    .clr_alarm_i (clr_alarm_i),
    .reg_wr_i    (reg_wr_i),
    .irq_o       (irq_o),
    .inta_i      (inta_i),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o)
);

// File: tb/irq_share_unit_bench.sv
module irq_share_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_kbd_i = 0, src_aux_i = 0, src_alarm_i = 0;
    logic       clr_kbd_i = 0, clr_aux_i = 0, clr_alarm_i = 0;
    logic [1:0] reg_sel_i = 0;
    logic       reg_wr_i = 0;
    logic [7:0] reg_wdata_i = 0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;
    logic       inta_i = 0;
    logic       vec_valid_o;
    logic [7:0] vec_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_share_unit u_irq_share_unit (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] sel, output logic [7:0] v);
        reg_sel_i = sel;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1;
        tick();
        reg_wr_i = 0;
    endtask

    task automatic clear_all();
        src_kbd_i = 0; src_aux_i = 0; src_alarm_i = 0;
        clr_kbd_i = 1; clr_aux_i = 1; clr_alarm_i = 1;
        tick();
        clr_kbd_i = 0; clr_aux_i = 0; clr_alarm_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 8'h00);
        rd(2'd1, v); chk("R1 mask", v, 8'h01);
        rd(2'd2, v); chk("R1 base", v, 8'h08);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 valid", {7'd0, vec_valid_o}, 8'h00);
        chk("R1 vec", vec_o, 8'h00);

        // R4 R5 R6 sweep of all source combinations under both mask values
        for (int m = 0; m < 2; m++) begin
            wr(2'd1, 8'(m));
            for (int c = 0; c < 8; c++) begin
                src_kbd_i = c[0]; src_aux_i = c[1]; src_alarm_i = c[2];
                tick();
                rd(2'd0, v);
                chk("R5 status sweep", v, 8'(c << 2));
                chk("R4 R6 irq sweep", {7'd0, irq_o},
                    {7'd0, c[0] | c[1] | (c[2] & (m == 0))});
                clear_all();
                rd(2'd0, v); chk("R3 cleared", v, 8'h00);
                chk("R4 irq cleared", {7'd0, irq_o}, 8'h00);
            end
        end

        // R3 pending held with no clear
        src_aux_i = 1; tick(); src_aux_i = 0;
        repeat (5) tick();
        rd(2'd0, v); chk("R3 held", v, 8'h08);
        chk("R3 irq held", {7'd0, irq_o}, 8'h01);
        clear_all();

        // R2 level held high across clear does not re-latch
        src_kbd_i = 1; tick();
        clr_kbd_i = 1; tick(); clr_kbd_i = 0;
        repeat (3) tick();
        rd(2'd0, v); chk("R2 no relatch", v, 8'h00);
        chk("R2 irq quiet", {7'd0, irq_o}, 8'h00);
        // R3 rising edge together with clear wins
        src_kbd_i = 0; tick();
        src_kbd_i = 1; clr_kbd_i = 1; tick(); clr_kbd_i = 0;
        rd(2'd0, v); chk("R3 set wins", v, 8'h04);
        clear_all();

        // R6 mask keeps only bit 0
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R6 mask readback", v, 8'h01);
        // R7 unused select ignored
        wr(2'd2, 8'h40);
        wr(2'd3, 8'hAA);
        rd(2'd3, v); chk("R7 sel3 reads zero", v, 8'h00);
        rd(2'd1, v); chk("R7 sel3 mask intact", v, 8'h01);
        rd(2'd2, v); chk("R7 sel3 base intact", v, 8'h40);

        // R7 R8 R9 every initialisation word, then an acknowledge
        for (int b = 0; b < 256; b++) begin
            wr(2'd2, 8'(b));
            rd(2'd2, v); chk("R7 base readback", v, 8'(b) & 8'hF8);
            inta_i = 1; tick();
            chk("R8 valid", {7'd0, vec_valid_o}, 8'h01);
            chk("R8 fixed vector", vec_o, 8'h71);
            tick();
            chk("R9 hold no valid", {7'd0, vec_valid_o}, 8'h00);
            chk("R8 vec zero idle", vec_o, 8'h00);
            tick();
            chk("R9 hold still", {7'd0, vec_valid_o}, 8'h00);
            inta_i = 0; tick();
            chk("R9 back idle", {7'd0, vec_valid_o}, 8'h00);
        end

        // R8 short acknowledge pulse returns straight to idle, then a second one
        inta_i = 1; tick(); inta_i = 0;
        chk("R8 pulse valid", {7'd0, vec_valid_o}, 8'h01);
        tick();
        chk("R8 pulse ends", {7'd0, vec_valid_o}, 8'h00);
        inta_i = 1; tick(); inta_i = 0;
        chk("R8 second pulse", vec_o, 8'h71);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule